// File: doc/BRIEF.md
# Dual-Rail Logic Unit with Completion Detection

This block evaluates a small bitwise function on operands carried in a delay-insensitive two-wire code. Every logical bit travels on a pair of wires: one pair value means one, another means zero, and both wires low means "no data yet" (the spacer). The datapath computes `y = (a AND b) OR (NOT c)` bit by bit, using a dual-rail AND, a dual-rail OR built from the AND by swapping rails, and a dual-rail inverter that is nothing more than a wire swap. Because validity travels inside the code, the result announces itself: no matched delay line is needed.

A completion detector watches the per-bit validity of the result. It is a balanced tree of two-input Muller C-elements, each modelled as a clocked state-holding flop so the block stays synthesizable. The tree's root is the `done` flag. It rises once every result bit holds a value and falls once every result bit is back at the spacer. A partly valid or partly empty result leaves `done` where it was. Users alternate a compute phase (drive valid operands, wait for `done` high) and a return phase (drive all spacers, wait for `done` low).

A separate flag reports an illegal input code, a bit whose two wires are both high.

Top module: `dr_logic_unit`

## Requirements
- R1: Bit i of every dual-rail vector uses position 2i+1 as its true wire and position 2i as its false wire. The pair (1,0) means logic 1, (0,1) means logic 0, and (0,0) is the spacer. With legal inputs, no result bit ever has both wires high.
- R2: When all three operands are fully valid, the decoded result equals `(a & b) | ~c` bit by bit, and every result bit is valid.
- R3: When all operands are entirely spacer, the result is entirely spacer.
- R4: After every result bit becomes valid, `done` rises exactly 3 clock edges later (for the default 8-bit width), and it does not rise earlier.
- R5: After every result bit returns to spacer, `done` falls exactly 3 clock edges later.
- R6: While the result is only partly valid, `done` keeps its previous value. From low it stays low, and from high it stays high.
- R7: `err` is high on the cycle after any operand bit has both wires high, and low on the cycle after no operand bit does.
- R8: During and immediately after reset, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the C-element state and error flag |
| rst_n | input | 1 | Active-low synchronous reset |
| a_dr | input | 2*W | Operand a, dual-rail packed |
| b_dr | input | 2*W | Operand b, dual-rail packed |
| c_dr | input | 2*W | Operand c, dual-rail packed (inverted inside) |
| y_dr | output | 2*W | Result `(a AND b) OR (NOT c)`, dual-rail packed |
| done | output | 1 | Completion flag: high after full validity, low after full return to spacer |
| err | output | 1 | Illegal-code flag, registered |

## Verification
A C-element node stuck at its old value, or one that follows a single input, shows at the ports as `done` rising or falling at the wrong edge. It can also show as `done` never leaving its level. The fault is visible within the 3-edge window after a phase change, or when a half-valid operand pattern is held. A swapped rail or a wrong gate term shows at once as a decoded miscompare on `y_dr` against a single-rail reference. It can also show as a result bit that never becomes valid, which stalls `done`. A wrong illegal-code detector shows one cycle after the offending pattern is driven.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // A dual-rail bit: [1] true wire, [0] false wire.
  typedef logic [1:0] drbit_t;

  localparam drbit_t DR_SPACER = 2'b00;

  function automatic drbit_t dr_not(input drbit_t x);
    return {x[0], x[1]};
  endfunction

  function automatic drbit_t dr_and(input drbit_t x, input drbit_t y);
    return {x[1] & y[1], x[0] | y[0]};
  endfunction

  // OR is AND with rails exchanged on both sides.
  function automatic drbit_t dr_or(input drbit_t x, input drbit_t y);
    return dr_not(dr_and(dr_not(x), dr_not(y)));
  endfunction

  function automatic logic dr_valid(input drbit_t x);
    return x[1] | x[0];
  endfunction

  function automatic logic dr_illegal(input drbit_t x);
    return x[1] & x[0];
  endfunction

  function automatic drbit_t dr_from_bit(input logic v);
    return {v, ~v};
  endfunction

  function automatic logic dr_to_bit(input drbit_t x);
    return x[1];
  endfunction
endpackage

// File: rtl/dr_celem.sv
module dr_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          q <= 1'b0;
    else if (a && b)     q <= 1'b1;
    else if (!a && !b)   q <= 1'b0;
  end
endmodule

// File: rtl/dr_ctree.sv
module dr_ctree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] leaf,
  output logic         root
);
  localparam int LVL   = (N > 1) ? $clog2(N) : 1;
  localparam int NLEAF = 1 << LVL;
  localparam int NINT  = NLEAF - 1;

  logic [NLEAF-1:0] pl;
  logic [NINT-1:0]  q;

  // Pad to a power of two with copies of leaf 0 so padding always agrees.
  for (genvar i = 0; i < NLEAF; i++) begin : g_pad
    if (i < N) begin : g_real
      assign pl[i] = leaf[i];
    end else begin : g_copy
      assign pl[i] = leaf[0];
    end
  end

  // Heap layout: node k has children 2k+1 and 2k+2; indices >= NINT are leaves.
  for (genvar k = 0; k < NINT; k++) begin : g_node
    logic in_l, in_r;
    if (2*k+1 >= NINT) begin : g_from_leaf
      assign in_l = pl[2*k+1-NINT];
      assign in_r = pl[2*k+2-NINT];
    end else begin : g_from_node
      assign in_l = q[2*k+1];
      assign in_r = q[2*k+2];
    end
    dr_celem u_c (.clk(clk), .rst_n(rst_n), .a(in_l), .b(in_r), .q(q[k]));
  end

  assign root = q[0];
endmodule

// File: rtl/dr_datapath.sv
module dr_datapath
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2*W-1:0] a,
  input  logic [2*W-1:0] b,
  input  logic [2*W-1:0] c,
  output logic [2*W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    drbit_t ab, nc;
    assign ab = dr_and(a[2*i +: 2], b[2*i +: 2]);
    assign nc = dr_not(c[2*i +: 2]);
    assign y[2*i +: 2] = dr_or(ab, nc);
  end
endmodule

// File: rtl/dr_logic_unit.sv
module dr_logic_unit
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*W-1:0] a_dr,
  input  logic [2*W-1:0] b_dr,
  input  logic [2*W-1:0] c_dr,
  output logic [2*W-1:0] y_dr,
  output logic           done,
  output logic           err
);
  // Named internal events for the checker.
  logic [W-1:0] out_valid;
  logic [W-1:0] bad_bit;
  logic         out_valid_all;
  logic         out_empty_all;
  logic         in_illegal;

  dr_datapath #(.W(W)) u_dp (.a(a_dr), .b(b_dr), .c(c_dr), .y(y_dr));

  for (genvar i = 0; i < W; i++) begin : g_mon
    assign out_valid[i] = dr_valid(y_dr[2*i +: 2]);
    assign bad_bit[i]   = dr_illegal(a_dr[2*i +: 2]) | dr_illegal(b_dr[2*i +: 2])
                        | dr_illegal(c_dr[2*i +: 2]);
  end

  assign out_valid_all = &out_valid;
  assign out_empty_all = ~|out_valid;
  assign in_illegal    = |bad_bit;

  dr_ctree #(.N(W)) u_tree (.clk(clk), .rst_n(rst_n), .leaf(out_valid), .root(done));

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= in_illegal;
  end
endmodule

// File: rtl/dr_logic_unit_chk.sv
module dr_logic_unit_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] a_dr,
  input logic [2*W-1:0] b_dr,
  input logic [2*W-1:0] c_dr,
  input logic [2*W-1:0] y_dr,
  input logic           done,
  input logic           err,
  input logic           out_valid_all,
  input logic           out_empty_all,
  input logic           in_illegal
);
  logic [W-1:0] y_both;
  for (genvar i = 0; i < W; i++) begin : g_b
    assign y_both[i] = y_dr[2*i+1] & y_dr[2*i];
  end

  AST_Y_RAILS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_illegal |-> (y_both == '0)); // R1
  AST_SPACER_IN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_dr == '0 && b_dr == '0 && c_dr == '0) |-> (y_dr == '0)); // R3
  AST_DONE_RISE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid_all)); // R4
  AST_DONE_FALL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(out_empty_all)); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_illegal |=> err); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_illegal |=> !err); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!done && !err)); // R8
endmodule

bind dr_logic_unit dr_logic_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr), .c_dr(c_dr),
  .y_dr(y_dr), .done(done), .err(err), .out_valid_all(out_valid_all),
  .out_empty_all(out_empty_all), .in_illegal(in_illegal)
);

// File: tb/tb_dr_logic_unit.sv
module tb_dr_logic_unit;
  localparam int W   = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*W-1:0] a_dr = '0, b_dr = '0, c_dr = '0;
  logic [2*W-1:0] y_dr;
  logic done, err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  typedef struct { logic [W-1:0] exp; int t0; } item_t;
  item_t sb[$];

  dr_logic_unit #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr),
    .c_dr(c_dr), .y_dr(y_dr), .done(done), .err(err));

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  // Bench-side encoding: true wire at 2i+1, false wire at 2i (R1).
  function automatic logic [2*W-1:0] enc(input logic [W-1:0] v);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[2*i+1] = v[i];
      r[2*i]   = !v[i];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] dec(input logic [2*W-1:0] r);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (r[2*i+1] == 1'b1) && (r[2*i] == 1'b0);
    return v;
  endfunction

  function automatic bit all_one_hot(input logic [2*W-1:0] r);
    for (int i = 0; i < W; i++) if ((r[2*i+1] ^ r[2*i]) != 1'b1) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected item when done rises.
  bit done_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_seen) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected done rise", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc - it.t0 == LAT, "R4 rise latency", cyc - it.t0, LAT);
          check(dec(y_dr) == it.exp, "R2 result", dec(y_dr), it.exp);
          check(all_one_hot(y_dr), "R1 result rails", y_dr, enc(it.exp));
        end
      end
      done_seen = done;
    end
  end

  task automatic wait_drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic to_spacer();
    int t0;
    @(negedge clk);
    a_dr = '0; b_dr = '0; c_dr = '0;
    t0 = cyc;
    #1 check(y_dr == '0, "R3 spacer out", y_dr, 0);
    while (done) @(negedge clk);
    check(cyc - t0 == LAT, "R5 fall latency", cyc - t0, LAT);
  endtask

  task automatic run_vec(input logic [W-1:0] av, bv, cv);
    item_t it;
    @(negedge clk);
    a_dr = enc(av); b_dr = enc(bv); c_dr = enc(cv);
    it.exp = (av & bv) | ~cv;
    it.t0 = cyc;
    sb.push_back(it);
    wait_drain();
    to_spacer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8 done in reset", done, 0);
    check(err == 1'b0, "R8 err in reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && err == 1'b0, "R8 after reset", {done, err}, 0);
    check(y_dr == '0, "R3 idle spacer", y_dr, 0);

    run_vec(8'h00, 8'h00, 8'h00);
    run_vec(8'hFF, 8'hFF, 8'hFF);
    run_vec(8'hF0, 8'h3C, 8'hAA);
    run_vec(8'h55, 8'hAA, 8'hFF);
    for (int k = 0; k < 20; k++) run_vec($urandom, $urandom, $urandom);

    // R6: half-valid operands keep done low.
    @(negedge clk);
    a_dr = enc(8'h0F) & 16'h00FF; b_dr = enc(8'h03) & 16'h00FF; c_dr = enc(8'h05) & 16'h00FF;
    repeat (6) @(negedge clk);
    check(done == 1'b0, "R6 partial valid holds low", done, 0);
    begin
      item_t it;
      a_dr = enc(8'h9F); b_dr = enc(8'hC3); c_dr = enc(8'hE5);
      it.exp = (8'h9F & 8'hC3) | ~8'hE5;
      it.t0 = cyc;
      sb.push_back(it);
    end
    wait_drain();
    // R6: half return to spacer keeps done high.
    @(negedge clk);
    a_dr &= 16'hFF00; b_dr &= 16'hFF00; c_dr &= 16'hFF00;
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R6 partial empty holds high", done, 1);
    to_spacer();

    // R7: illegal code on one bit.
    @(negedge clk);
    a_dr = 16'h0003;
    @(negedge clk);
    check(err == 1'b1, "R7 err set", err, 1);
    a_dr = '0;
    @(negedge clk);
    check(err == 1'b0, "R7 err clear", err, 0);
    check(done == 1'b0, "R6 no done after illegal", done, 0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule